// File: doc/BRIEF.md
# QPSK Viterbi Add-Compare-Select Unit

This block performs the per-symbol metric update of a rate-1/2, constraint-length-7 Viterbi decoder whose code uses the generator pair 171 and 133 (octal). It takes one soft QPSK symbol, given as signed 6-bit in-phase and quadrature samples, through a valid/ready handshake. From that symbol it forms four offset distance metrics and packs them into one 32-bit word. It then sweeps the 32 butterflies of the 64-state trellis, one butterfly per clock.

Each butterfly adds branch metrics to the two predecessor path metrics and keeps the smaller sum for each of its two successor states. It records one decision bit per successor. Path metrics are 11-bit values that are allowed to wrap, and they are compared modulo 2048. At the end of the sweep the block presents the 64-bit decision vector for a traceback unit, together with the index and value of the best surviving path metric.

Top module: `qpsk_acs_unit`

## Requirements
- R1: The branch metric word carries I+Q+127 in bits [7:0], I-Q+127 in bits [15:8], -I+Q+127 in bits [23:16] and -I-Q+127 in bits [31:24]. Metric k serves code pair (c0,c1) with k = 2*c0 + c1. The two metrics of each complementary pair always sum to 254.
- R2: An input sample of -32 is treated as -31, so valid soft values span -31..+31.
- R3: Butterfly j (0..31) reads the metrics of states 2j and 2j+1 and writes states j and j+32. The code index c is (parity(r & 171o), parity(r & 133o)) with r = 2j, taken as a 7-bit register. The transitions 2j->j and 2j+1->j+32 use metric c, and the other two transitions use metric 3-c.
- R4: Metrics are distances and the smaller one survives. A is smaller than B when bit 10 of the 11-bit difference (A-B) is set. On a tie the path from the even predecessor survives.
- R5: After reset, state 0 holds metric 0 and every other state holds 256.
- R6: Bit s of the decision vector is 1 when state s took its path from odd predecessor 2*(s mod 32)+1, and 0 when it took the path from the even predecessor.
- R7: The best state is the smallest new metric. Candidates are visited in the order 0, 32, 1, 33, ..., 31, 63, and a later candidate replaces the current one only if it is strictly smaller. The best value is that state's metric.
- R8: After a symbol is accepted, in_ready is low. The result appears as a one-cycle dec_valid pulse exactly 32 clock edges after the accepting edge. in_ready is high again during that pulse.
- R9: Path metric additions wrap modulo 2048, and decoding stays correct over long runs in which metrics pass 2047.
- R10: During and right after reset, in_ready is 1 and dec_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Soft symbol offered |
| in_ready | output | 1 | Unit idle, symbol can be taken |
| in_i | input | 6 | Signed soft in-phase sample |
| in_q | input | 6 | Signed soft quadrature sample |
| dec_valid | output | 1 | One-cycle strobe: decisions and best metric are valid |
| dec_bits | output | 64 | Survivor decision per state |
| best_state | output | 6 | Index of the smallest path metric |
| best_metric | output | 11 | Value of the smallest path metric |

## Verification
The bench targets four corner cases, each with a distinct failure signature.

Ties come from repeated zero-valued symbols, which make all four branch metrics equal. A design that broke ties toward the odd predecessor, or let later best-state candidates win on equality, would flip decision bits or report the wrong best state.

Long random runs push every metric past 2047. A plain magnitude compare would then pick the wrong survivors once the values wrap.

Samples of -32 test saturation. Without it the branch metrics shift by one and every later metric drifts from the reference.

The first symbol after reset exposes a wrong initial bias or a swapped operand pairing. Either error shows up at once in the decisions of states fed from state 0.

// File: rtl/acs_pkg.sv
package acs_pkg;
    localparam int K        = 7;
    localparam int NS       = 1 << (K - 1);
    localparam int NBF      = NS / 2;
    localparam int SW       = $clog2(NS);
    localparam int JW       = $clog2(NBF);
    localparam int SOFT_W   = 6;
    localparam int BM_W     = 8;
    localparam int PM_W     = 11;
    localparam int BM_OFS   = 127;
    localparam int INIT_PM  = 256;
    localparam logic [K-1:0] GEN_A = 7'o171;
    localparam logic [K-1:0] GEN_B = 7'o133;

    typedef logic [PM_W-1:0] pm_t;
    typedef logic [BM_W-1:0] bm_t;

    typedef struct packed {
        bm_t m3;
        bm_t m2;
        bm_t m1;
        bm_t m0;
    } bm_word_t;

    function automatic logic pm_less(pm_t a, pm_t b);
        pm_t d;
        d = a - b;
        return d[PM_W-1];
    endfunction

    function automatic bm_t bm_pick(bm_word_t w, logic [1:0] k);
        case (k)
            2'd0:    return w.m0;
            2'd1:    return w.m1;
            2'd2:    return w.m2;
            default: return w.m3;
        endcase
    endfunction

    function automatic logic [1:0] pair_code(logic [JW-1:0] j);
        logic [K-1:0] r;
        r = {1'b0, j, 1'b0};
        return {^(r & GEN_A), ^(r & GEN_B)};
    endfunction
endpackage

// File: rtl/acs_bmu.sv
module acs_bmu
    import acs_pkg::*;
(
    input  logic [SOFT_W-1:0] soft_i,
    input  logic [SOFT_W-1:0] soft_q,
    output bm_word_t          bm
);
    localparam int EW = BM_W + 2;
    localparam logic [SOFT_W-1:0] MOST_NEG = {1'b1, {(SOFT_W-1){1'b0}}};

    logic [SOFT_W-1:0] ic, qc;
    logic signed [EW-1:0] iw, qw, s0, s1, s2, s3;

    always_comb begin
        ic = (soft_i == MOST_NEG) ? MOST_NEG + 1'b1 : soft_i;
        qc = (soft_q == MOST_NEG) ? MOST_NEG + 1'b1 : soft_q;
        iw = {{(EW-SOFT_W){ic[SOFT_W-1]}}, ic};
        qw = {{(EW-SOFT_W){qc[SOFT_W-1]}}, qc};
        s0 = EW'(BM_OFS) + iw + qw;
        s1 = EW'(BM_OFS) + iw - qw;
        s2 = EW'(BM_OFS) - iw + qw;
        s3 = EW'(BM_OFS) - iw - qw;
        bm.m0 = s0[BM_W-1:0];
        bm.m1 = s1[BM_W-1:0];
        bm.m2 = s2[BM_W-1:0];
        bm.m3 = s3[BM_W-1:0];
    end
endmodule

// File: rtl/acs_bfly.sv
module acs_bfly
    import acs_pkg::*;
(
    input  pm_t        pm_even,
    input  pm_t        pm_odd,
    input  bm_word_t   bm,
    input  logic [1:0] code,
    output pm_t        pm_lo,
    output pm_t        pm_hi,
    output logic       dec_lo,
    output logic       dec_hi
);
    pm_t bc, bn, lo_e, lo_o, hi_e, hi_o;

    always_comb begin
        bc   = PM_W'(bm_pick(bm, code));
        bn   = PM_W'(bm_pick(bm, ~code));
        lo_e = pm_even + bc;
        lo_o = pm_odd  + bn;
        hi_e = pm_even + bn;
        hi_o = pm_odd  + bc;
        dec_lo = pm_less(lo_o, lo_e);
        dec_hi = pm_less(hi_o, hi_e);
        pm_lo  = dec_lo ? lo_o : lo_e;
        pm_hi  = dec_hi ? hi_o : hi_e;
    end
endmodule

// File: rtl/acs_pmbank.sv
module acs_pmbank
    import acs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [JW-1:0] idx,
    input  logic          wr_en,
    input  logic          swap,
    input  pm_t           new_lo,
    input  pm_t           new_hi,
    output pm_t           rd_even,
    output pm_t           rd_odd
);
    pm_t  bank [2][NS];
    logic sel;

    assign rd_even = bank[sel][{idx, 1'b0}];
    assign rd_odd  = bank[sel][{idx, 1'b1}];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= 1'b0;
            for (int b = 0; b < 2; b++)
                for (int s = 0; s < NS; s++)
                    bank[b][s] <= (s == 0) ? pm_t'(0) : pm_t'(INIT_PM);
        end else begin
            if (wr_en) begin
                bank[~sel][{1'b0, idx}] <= new_lo;
                bank[~sel][{1'b1, idx}] <= new_hi;
            end
            if (swap) sel <= ~sel;
        end
    end
endmodule

// File: rtl/qpsk_acs_unit.sv
module qpsk_acs_unit
    import acs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SOFT_W-1:0] in_i,
    input  logic [SOFT_W-1:0] in_q,
    output logic              dec_valid,
    output logic [NS-1:0]     dec_bits,
    output logic [SW-1:0]     best_state,
    output logic [PM_W-1:0]   best_metric
);
    bm_word_t      bm_new, bm_q;
    logic          busy, last;
    logic [JW-1:0] cnt;
    pm_t           rd_even, rd_odd, pm_lo, pm_hi;
    logic          d_lo, d_hi;
    logic [NS-1:0] dec_q;
    logic          dv_q;
    pm_t           best_pm_q, step_pm, next_pm;
    logic [SW-1:0] best_ix_q, step_ix, next_ix;

    acs_bmu u_bmu (.soft_i(in_i), .soft_q(in_q), .bm(bm_new));

    acs_pmbank u_bank (
        .clk(clk), .rst(rst), .idx(cnt), .wr_en(busy), .swap(busy && last),
        .new_lo(pm_lo), .new_hi(pm_hi), .rd_even(rd_even), .rd_odd(rd_odd)
    );

    acs_bfly u_bfly (
        .pm_even(rd_even), .pm_odd(rd_odd), .bm(bm_q), .code(pair_code(cnt)),
        .pm_lo(pm_lo), .pm_hi(pm_hi), .dec_lo(d_lo), .dec_hi(d_hi)
    );

    assign last = (cnt == JW'(NBF - 1));

    // running best: state cnt first, then cnt+NBF; strictly smaller replaces
    always_comb begin
        if (cnt == '0 || pm_less(pm_lo, best_pm_q)) begin
            step_pm = pm_lo;
            step_ix = {1'b0, cnt};
        end else begin
            step_pm = best_pm_q;
            step_ix = best_ix_q;
        end
        if (pm_less(pm_hi, step_pm)) begin
            next_pm = pm_hi;
            next_ix = {1'b1, cnt};
        end else begin
            next_pm = step_pm;
            next_ix = step_ix;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            cnt       <= '0;
            bm_q      <= '0;
            dec_q     <= '0;
            dv_q      <= 1'b0;
            best_pm_q <= '0;
            best_ix_q <= '0;
        end else begin
            dv_q <= 1'b0;
            if (!busy) begin
                if (in_valid) begin
                    bm_q <= bm_new;
                    busy <= 1'b1;
                    cnt  <= '0;
                end
            end else begin
                dec_q[{1'b0, cnt}] <= d_lo;
                dec_q[{1'b1, cnt}] <= d_hi;
                best_pm_q <= next_pm;
                best_ix_q <= next_ix;
                cnt <= cnt + 1'b1;
                if (last) begin
                    busy <= 1'b0;
                    dv_q <= 1'b1;
                end
            end
        end
    end

    assign in_ready    = !busy;
    assign dec_valid   = dv_q;
    assign dec_bits    = dec_q;
    assign best_state  = best_ix_q;
    assign best_metric = best_pm_q;

    // R8
    accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);
    // R8
    dec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);
    // R8
    ready_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> in_ready);
    // R1
    bm_pair_sum_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> ((9'(bm_q.m0) + 9'(bm_q.m3) == 9'd254) &&
                  (9'(bm_q.m1) + 9'(bm_q.m2) == 9'd254)));
    // R2
    bm_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bm_q.m0 >= 8'd65 && bm_q.m0 <= 8'd189 &&
                  bm_q.m1 >= 8'd65 && bm_q.m1 <= 8'd189));
endmodule

// File: tb/qpsk_acs_unit_test.sv
module qpsk_acs_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [5:0]  in_i = '0, in_q = '0;
    logic        dec_valid;
    logic [63:0] dec_bits;
    logic [5:0]  best_state;
    logic [10:0] best_metric;

    qpsk_acs_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_i(in_i), .in_q(in_q), .dec_valid(dec_valid), .dec_bits(dec_bits),
        .best_state(best_state), .best_metric(best_metric)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic [63:0] dec;
        logic [5:0]  bs;
        logic [10:0] bv;
        logic [31:0] acc;
    } exp_t;

    exp_t exq[$];
    int   checks = 0, errors = 0;
    int   cyc = 0;
    int   ref_pm[64];
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit mless(int a, int b);
        return (((a - b) & 2047) >= 1024);
    endfunction

    function automatic exp_t ref_step(int si, int sq);
        exp_t e;
        int bm[4], nw[64], c, a0, a1, b0, b1;
        logic [6:0] r;
        if (si == -32) si = -31;   // R2
        if (sq == -32) sq = -31;
        bm[0] = si + sq + 127;     // R1
        bm[1] = si - sq + 127;
        bm[2] = -si + sq + 127;
        bm[3] = -si - sq + 127;
        e = '0;
        for (int j = 0; j < 32; j++) begin
            r = 7'(j << 1);         // R3
            c = {30'd0, ^(r & 7'o171), ^(r & 7'o133)};
            a0 = (ref_pm[2*j] + bm[c]) & 2047;
            a1 = (ref_pm[2*j+1] + bm[3-c]) & 2047;
            b0 = (ref_pm[2*j] + bm[3-c]) & 2047;
            b1 = (ref_pm[2*j+1] + bm[c]) & 2047;
            e.dec[j]    = mless(a1, a0);   // R4 R6
            e.dec[j+32] = mless(b1, b0);
            nw[j]    = e.dec[j] ? a1 : a0;
            nw[j+32] = e.dec[j+32] ? b1 : b0;
        end
        e.bs = 0;                          // R7
        for (int j = 0; j < 32; j++) begin
            if (j != 0 && mless(nw[j], nw[e.bs])) e.bs = 6'(j);
            if (mless(nw[j+32], nw[e.bs])) e.bs = 6'(j + 32);
        end
        e.bv = 11'(nw[e.bs]);
        for (int s = 0; s < 64; s++) ref_pm[s] = nw[s];
        return e;
    endfunction

    task automatic send(int si, int sq);
        exp_t e;
        e = ref_step(si, sq);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_i = 6'(si);
        in_q = 6'(sq);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        e.acc = 32'(cyc);
        chk(in_ready == 1'b0, "R8", "in_ready after accept", in_ready, 0);
        exq.push_back(e);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && dec_valid) begin
            exp_t e;
            if (exq.size() == 0) begin
                chk(0, "R8", "unexpected dec_valid", 1, 0);
            end else begin
                e = exq.pop_front();
                chk(dec_bits == e.dec, "R6", "decision vector", dec_bits, e.dec);
                chk(best_state == e.bs, "R7", "best state", best_state, e.bs);
                chk(best_metric == e.bv, "R9", "best metric", best_metric, e.bv);
                chk(cyc == int'(e.acc) + 32, "R8", "latency", cyc - int'(e.acc), 32);
                chk(in_ready == 1'b1, "R8", "in_ready at done", in_ready, 1);
            end
        end
    end

    initial begin
        #600000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 64; s++) ref_pm[s] = (s == 0) ? 0 : 256;  // R5
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R10", "in_ready in reset", in_ready, 1);
        chk(dec_valid == 1'b0, "R10", "dec_valid in reset", dec_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
        chk(dec_valid == 1'b0, "R10", "dec_valid after reset", dec_valid, 0);
        // R5 R3: first symbol from reset state
        send(-31, -31);
        send(31, 31);
        send(31, -31);
        send(-31, 31);
        // R2: saturation of most negative sample
        send(-32, -32);
        send(-32, 20);
        send(5, -32);
        // R4: all branch metrics equal gives ties
        for (int k = 0; k < 8; k++) send(0, 0);
        // R9: long random run wraps metrics
        for (int k = 0; k < 150; k++)
            send(int'($urandom_range(0, 63)) - 32, int'($urandom_range(0, 63)) - 32);
        while (exq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule